// File: doc/BRIEF.md
# Combining Fetch-and-Add Unit

This block holds one shared accumulator and serves several requesters that each want to add an amount to it and learn the value the accumulator had "just before" their own addition. Every request that arrives in the same clock cycle is folded into one prefix computation and retired as one indivisible step. No requester waits behind another, and the cost in cycles does not depend on how many requesters are active.

Within a cycle the active requesters are ranked by ascending index. The lowest-ranked active requester receives the accumulator's current value. Each higher-ranked requester receives that value plus the amounts of all active requesters ranked below it. The accumulator then advances by the total of all active amounts.

Results and grants are registered and appear one cycle after the request. A load port can overwrite the accumulator; a load wins over any requests in the same cycle, and those requests are refused.

Top module: `psum_unit`

## Requirements
- R1: After reset the accumulator is 0 and `req_grant` is all zeros; the first request after reset returns 0.
- R2: A lone active requester with amount A receives the accumulator value B one cycle later, and the accumulator becomes B+A.
- R3: When several requesters are active in one cycle, requester i receives B plus the sum of the amounts of the active requesters with index below i.
- R4: After a combined step the accumulator equals B plus the sum of all active amounts, which the next request observes.
- R5: All requesters active in a cycle receive `req_grant` together in the following cycle; `req_grant[i]` is high exactly when requester i was active in the previous cycle and no load occurred.
- R6: An inactive requester contributes zero to every prefix and to the accumulator, and is not granted.
- R7: All sums wrap modulo 2^W; no overflow indication exists.
- R8: When `init_en` is high, the accumulator takes `init_val`, all same-cycle requests are refused (`req_grant` all zeros next cycle), and their amounts are not added.
- R9: An accumulator update is visible to requests issued in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| init_en | input | 1 | Load the accumulator with `init_val` |
| init_val | input | W | Value to load |
| req_valid | input | NREQ | Per-requester request strobe |
| req_inc | input | NREQ*W | Per-requester amount, requester i at bits [i*W +: W] |
| req_grant | output | NREQ | Per-requester grant, one cycle after the request |
| req_result | output | NREQ*W | Per-requester returned prefix, requester i at bits [i*W +: W] |

## Verification
On every cycle the assertions check that grants mirror the previous cycle's strobes, that a load refuses all requests, that inactive requesters are never granted, and that any two neighbouring granted results differ by exactly the lower neighbour's amount. Absolute values need a model of the accumulator, so only the bench's scenarios show the returned base, the accumulator after combined steps and loads, and wraparound at the top of the range.

// File: rtl/psum_unit.sv
module psum_unit #(
  parameter int NREQ = 4,
  parameter int W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_en,
  input  logic [W-1:0]      init_val,
  input  logic [NREQ-1:0]   req_valid,
  input  logic [NREQ*W-1:0] req_inc,
  output logic [NREQ-1:0]   req_grant,
  output logic [NREQ*W-1:0] req_result
);

  logic [W-1:0] base_q;
  logic [W-1:0] pre [0:NREQ];

  assign pre[0] = base_q;

  for (genvar i = 0; i < NREQ; i++) begin : g_chain
    assign pre[i+1] = pre[i] + (req_valid[i] ? req_inc[i*W +: W] : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q     <= '0;
      req_grant  <= '0;
      req_result <= '0;
    end else if (init_en) begin
      base_q    <= init_val;
      req_grant <= '0;
    end else begin
      base_q    <= pre[NREQ];
      req_grant <= req_valid;
      for (int i = 0; i < NREQ; i++) req_result[i*W +: W] <= pre[i];
    end
  end

endmodule

// File: rtl/psum_unit_chk.sv
module psum_unit_chk #(
  parameter int NREQ = 4,
  parameter int W    = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              init_en,
  input logic [NREQ-1:0]   req_valid,
  input logic [NREQ*W-1:0] req_inc,
  input logic [NREQ-1:0]   req_grant,
  input logic [NREQ*W-1:0] req_result
);

  AST_GRANT_MIRRORS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(init_en)) |-> req_grant == $past(req_valid)); // R5

  AST_LOAD_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(init_en) |-> req_grant == '0); // R8

  for (genvar i = 0; i < NREQ; i++) begin : g_idle
    AST_IDLE_NOT_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(req_valid[i]) |-> !req_grant[i]); // R6
  end

  for (genvar i = 0; i + 1 < NREQ; i++) begin : g_step
    AST_PREFIX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (req_grant[i] && req_grant[i+1]) |->
        req_result[(i+1)*W +: W] == W'(req_result[i*W +: W] + $past(req_inc[i*W +: W]))); // R3
  end

endmodule

bind psum_unit psum_unit_chk #(.NREQ(NREQ), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .init_en(init_en), .req_valid(req_valid),
  .req_inc(req_inc), .req_grant(req_grant), .req_result(req_result)
);

// File: tb/psum_unit_test.sv
`timescale 1ns/1ps
module psum_unit_test;
  localparam int N = 4;
  localparam int W = 16;

  logic clk = 0;
  logic rst_n = 0;
  logic init_en = 0;
  logic [W-1:0] init_val = '0;
  logic [N-1:0] req_valid = '0;
  logic [N*W-1:0] req_inc = '0;
  logic [N-1:0] req_grant;
  logic [N*W-1:0] req_result;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] mbase;

  always #2.5 clk = ~clk;

  psum_unit #(.NREQ(N), .W(W)) uut (
    .clk(clk), .rst_n(rst_n), .init_en(init_en), .init_val(init_val),
    .req_valid(req_valid), .req_inc(req_inc),
    .req_grant(req_grant), .req_result(req_result)
  );

  // {init, init_val, valid, inc3, inc2, inc1, inc0}
  localparam logic [84:0] VEC [0:9] = '{
    {1'b0, 16'h0000, 4'b0001, 16'h0000, 16'h0000, 16'h0000, 16'h0005},
    {1'b0, 16'h0000, 4'b1111, 16'h0004, 16'h0003, 16'h0002, 16'h0001},
    {1'b0, 16'h0000, 4'b1010, 16'h0007, 16'h0009, 16'h0008, 16'h0006},
    {1'b0, 16'h0000, 4'b0000, 16'h0011, 16'h0022, 16'h0033, 16'h0044},
    {1'b1, 16'h1000, 4'b1111, 16'h0001, 16'h0001, 16'h0001, 16'h0001},
    {1'b0, 16'h0000, 4'b0100, 16'h0000, 16'h0002, 16'h0000, 16'h0000},
    {1'b0, 16'h0000, 4'b1001, 16'h0100, 16'h0050, 16'h0060, 16'h0030},
    {1'b1, 16'hFFFE, 4'b0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000},
    {1'b0, 16'h0000, 4'b1111, 16'h0001, 16'h0001, 16'h0001, 16'h0001},
    {1'b0, 16'h0000, 4'b0001, 16'h0000, 16'h0000, 16'h0000, 16'h0001}
  };

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge where the results are visible.
  task automatic apply(input logic ie, input logic [W-1:0] iv, input logic [N-1:0] v,
                       input logic [N*W-1:0] inc, input string tag);
    logic [W-1:0] acc;
    logic [W-1:0] exp_r [N];
    acc = mbase;
    for (int i = 0; i < N; i++) begin
      exp_r[i] = acc;
      if (v[i]) acc = acc + inc[i*W +: W];
    end
    init_en = ie; init_val = iv; req_valid = v; req_inc = inc;
    @(negedge clk);
    init_en = 0; req_valid = '0;
    chk(req_grant == (ie ? '0 : v), tag, "grant", req_grant, ie ? 0 : v);
    if (!ie)
      for (int i = 0; i < N; i++)
        if (v[i]) chk(req_result[i*W +: W] == exp_r[i], tag, $sformatf("result%0d", i),
                      req_result[i*W +: W], exp_r[i]);
    mbase = ie ? iv : acc;
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    mbase = '0;
    repeat (3) @(negedge clk);
    chk(req_grant == '0, "R1", "grant in reset", req_grant, 0);
    rst_n = 1;
    @(negedge clk);
    chk(req_grant == '0, "R1", "grant after reset", req_grant, 0);
    apply(0, '0, 4'b0001, {16'd0, 16'd0, 16'd0, 16'd3}, "R1");

    for (int k = 0; k < 10; k++) begin
      string tag;
      logic [84:0] e;
      e = VEC[k];
      if (e[84]) tag = "R8";
      else if (e[67:64] == 4'b0000) tag = "R6";
      else if ($countones(e[67:64]) == 1) tag = "R2";
      else tag = "R3";
      apply(e[84], e[83:68], e[67:64], e[63:0], tag);
    end

    apply(0, '0, 4'b1111, {16'd10, 16'd20, 16'd30, 16'd40}, "R5");
    apply(0, '0, 4'b0001, '0, "R4");
    apply(1, 16'hFFF0, 4'b0000, '0, "R8");
    apply(0, '0, 4'b1111, {16'h0008, 16'h0008, 16'h0008, 16'h0008}, "R7");
    apply(0, '0, 4'b1000, {16'h0001, 16'd0, 16'd0, 16'd0}, "R7");
    apply(0, '0, 4'b0010, {16'd0, 16'd0, 16'h0005, 16'd0}, "R9");
    apply(0, '0, 4'b0100, {16'd0, 16'h0002, 16'd0, 16'd0}, "R9");
    apply(0, '0, 4'b0110, {16'h7777, 16'h0001, 16'h0001, 16'h7777}, "R6");
    apply(0, '0, 4'b0001, '0, "R4");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule